// File: doc/BRIEF.md
# Chip-Select Row Address Matcher

This block decides which of eight memory chip-select rows owns a node-local input address. Every row has a base register and a mask register. Bit 0 of the base register enables the row. The remaining register bits hold only selected address fields, in compressed form. A layout-select pin picks one of two register layouts. The layout sets which register bits are kept and how far they are shifted left to reach their full address positions. Address bits that no stored field covers are treated as don't-care when rows are compared.

Lookups travel on a valid/ready stream. When an address is accepted, every row is compared against it in parallel. One cycle later the block presents a registered result: a hit flag and the index of the lowest-numbered enabled row that matched. The output follows valid/ready back-pressure. A result stays on the outputs until it is taken, and no new address is accepted while a result is stalled.

Separately from the stream, the block drives the lowest and highest address that each row covers. These range outputs are combinational and follow the stored registers and the layout pin. Registers are loaded through a plain write strobe, with an index and a bank select.

Top module: `csm_matcher`

## Requirements
- R1: There are eight rows. Bit 0 of a row's base register is its enable. A row whose enable bit is clear is never reported as the matching row.
- R2: The expanded base of a row is its base register ANDed with the layout's field pattern, then shifted left by the layout's shift. With layout_new=0 the fields are register bits [31:21] and [15:9] and the shift is 4. With layout_new=1 the fields are bits [28:19] and [13:5] and the shift is 8.
- R3: The expanded mask of a row is built in two parts. The first part is the row's mask register ANDed with the same field pattern and shifted by the same amount. This is ORed with the inverse of the shifted field pattern. A 1 in the expanded mask marks a don't-care address bit.
- R4: A row matches when (addr AND NOT mask) equals (base AND NOT mask), taken over all 40 address bits.
- R5: When several enabled rows match, out_row reports the lowest row index and out_hit is 1.
- R6: When no enabled row matches, out_hit is 0 and out_row is 0.
- R7: With layout_new=0, row r uses mask register r. With layout_new=1, row r uses mask register r>>1, so rows share masks in pairs and mask registers 4 to 7 have no effect.
- R8: For row r, row_min[r*40 +: 40] equals base AND NOT mask. row_max[r*40 +: 40] equals base OR mask OR the layout's gap bits. The gap bits are [24:20] and [12:0] for layout_new=0, and [26:22] and [12:0] for layout_new=1.
- R9: in_valid and in_ready both high at a clock edge accept an address. Its result appears with out_valid one cycle later. in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_hit and out_row hold their values.
- R10: After reset, out_valid, out_hit and out_row are 0 and all registers are 0, so every row is disabled.
- R11: With cfg_we high at a clock edge, cfg_data is written to register cfg_idx. The mask bank is written when cfg_mask=1 and the base bank when cfg_mask=0. The written value applies to lookups accepted at later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_new | input | 1 | Register layout select (0 or 1) |
| cfg_we | input | 1 | Register write strobe |
| cfg_mask | input | 1 | 1 writes the mask bank, 0 writes the base bank |
| cfg_idx | input | 3 | Register index |
| cfg_data | input | 32 | Register write data |
| in_valid | input | 1 | Lookup address valid |
| in_ready | output | 1 | Block can accept a lookup |
| in_addr | input | 40 | Lookup address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Some enabled row matched |
| out_row | output | 3 | Lowest matching row, 0 on a miss |
| row_min | output | 320 | Lowest covered address of each row, row r at bits r*40 +: 40 |
| row_max | output | 320 | Highest covered address of each row, row r at bits r*40 +: 40 |

## Verification
Some properties are checked on every cycle. A reported row must have been enabled when its address was accepted. A miss must report row 0. A stalled result must stay unchanged. An accepted lookup must produce a valid result on the next cycle. Each row's minimum must have no bit set that is clear in its maximum. Other behaviour can only be shown by the bench's scenarios. These are the exact field positions and shifts of each layout, priority among overlapping rows, mask sharing in the paired layout, disabled rows, and the exact range values.

// File: rtl/csm_pkg.sv
package csm_pkg;
  // Layout 0: register fields [31:21],[15:9], placed 4 bits higher.
  localparam logic [31:0] LAY0_FIELDS = 32'hFFE0_FE00;
  localparam int unsigned LAY0_SHIFT  = 4;
  localparam logic [63:0] LAY0_GAP    = 64'h0000_0000_01F0_1FFF;
  // Layout 1: register fields [28:19],[13:5], placed 8 bits higher.
  localparam logic [31:0] LAY1_FIELDS = 32'h1FF8_3FE0;
  localparam int unsigned LAY1_SHIFT  = 8;
  localparam logic [63:0] LAY1_GAP    = 64'h0000_0000_07C0_1FFF;

  localparam int unsigned SHIFT_W = 4;
endpackage

// File: rtl/csm_cfg_store.sv
module csm_cfg_store #(
  parameter int ROWS  = 8,
  parameter int REG_W = 32,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic                        sel_mask,
  input  logic [IDX_W-1:0]            idx,
  input  logic [REG_W-1:0]            data,
  output logic [ROWS-1:0][REG_W-1:0]  base_q,
  output logic [ROWS-1:0][REG_W-1:0]  mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (we) begin
      if (sel_mask) mask_q[idx] <= data;
      else          base_q[idx] <= data;
    end
  end
endmodule

// File: rtl/csm_row_expand.sv
module csm_row_expand #(
  parameter int ADDR_W  = 40,
  parameter int REG_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic [REG_W-1:0]   base_reg,
  input  logic [REG_W-1:0]   mask_reg,
  input  logic [REG_W-1:0]   fields,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [ADDR_W-1:0]  gap,
  input  logic [ADDR_W-1:0]  addr,
  output logic               en,
  output logic               hit,
  output logic [ADDR_W-1:0]  lo,
  output logic [ADDR_W-1:0]  hi
);
  logic [ADDR_W-1:0] base_full, field_full, mask_full;

  always_comb begin
    base_full  = ADDR_W'(base_reg & fields) << shift;
    field_full = ADDR_W'(fields) << shift;
    mask_full  = (ADDR_W'(mask_reg & fields) << shift) | ~field_full;
    en         = base_reg[0];
    hit        = en && ((addr & ~mask_full) == (base_full & ~mask_full));
    lo         = base_full & ~mask_full;
    hi         = base_full | mask_full | gap;
  end
endmodule

// File: rtl/csm_prio_enc.sv
module csm_prio_enc #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/csm_matcher.sv
module csm_matcher #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 40,
  parameter int REG_W  = 32,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     layout_new,
  input  logic                     cfg_we,
  input  logic                     cfg_mask,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [REG_W-1:0]         cfg_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_hit,
  output logic [IDX_W-1:0]         out_row,
  output logic [ROWS*ADDR_W-1:0]   row_min,
  output logic [ROWS*ADDR_W-1:0]   row_max
);
  import csm_pkg::*;

  logic [ROWS-1:0][REG_W-1:0] base_q, mask_q;
  logic [REG_W-1:0]           cur_fields;
  logic [SHIFT_W-1:0]         cur_shift;
  logic [ADDR_W-1:0]          cur_gap;
  logic [ROWS-1:0]            row_en, row_hit;
  logic                       any_hit;
  logic [IDX_W-1:0]           win_row;
  logic                       accept;

  csm_cfg_store #(.ROWS(ROWS), .REG_W(REG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel_mask(cfg_mask),
    .idx(cfg_idx), .data(cfg_data), .base_q(base_q), .mask_q(mask_q)
  );

  always_comb begin
    cur_fields = layout_new ? REG_W'(LAY1_FIELDS) : REG_W'(LAY0_FIELDS);
    cur_shift  = layout_new ? SHIFT_W'(LAY1_SHIFT) : SHIFT_W'(LAY0_SHIFT);
    cur_gap    = layout_new ? ADDR_W'(LAY1_GAP) : ADDR_W'(LAY0_GAP);
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [REG_W-1:0] mask_sel;
    // paired layout: two neighbouring rows share one mask register
    assign mask_sel = layout_new ? mask_q[r >> 1] : mask_q[r];

    csm_row_expand #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SHIFT_W(SHIFT_W)) u_exp (
      .base_reg(base_q[r]), .mask_reg(mask_sel), .fields(cur_fields),
      .shift(cur_shift), .gap(cur_gap), .addr(in_addr),
      .en(row_en[r]), .hit(row_hit[r]),
      .lo(row_min[r*ADDR_W +: ADDR_W]), .hi(row_max[r*ADDR_W +: ADDR_W])
    );
  end

  csm_prio_enc #(.N(ROWS)) u_prio (.req(row_hit), .any(any_hit), .idx(win_row));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_row   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= any_hit;
      out_row   <= any_hit ? win_row : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csm_matcher_chk.sv
module csm_matcher_chk #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 40,
  localparam int IDX_W = $clog2(ROWS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   out_hit,
  input logic [IDX_W-1:0]       out_row,
  input logic [ROWS-1:0]        row_en,
  input logic [ROWS*ADDR_W-1:0] row_min,
  input logic [ROWS*ADDR_W-1:0] row_max
);
  logic [ROWS-1:0] en_at_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_at_accept <= '0;
    else if (in_valid && in_ready) en_at_accept <= row_en;
  end

  p_enabled_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> en_at_accept[out_row]);

  p_miss_row_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_row == '0);

  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_row));

  p_accept_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  for (genvar r = 0; r < ROWS; r++) begin : g_rng
    p_range_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (row_min[r*ADDR_W +: ADDR_W] & ~row_max[r*ADDR_W +: ADDR_W]) == '0);
  end
endmodule

bind csm_matcher csm_matcher_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
  .out_row(out_row), .row_en(row_en), .row_min(row_min), .row_max(row_max)
);

// File: tb/test_csm_matcher.sv
`timescale 1ns/1ps
module test_csm_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic layout_new = 1'b0, cfg_we = 1'b0, cfg_mask = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [39:0] in_addr = '0;
  logic in_ready, out_valid, out_hit;
  logic [2:0] out_row;
  logic [319:0] row_min, row_max;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csm_matcher i_csm_matcher (
    .clk(clk), .rst_n(rst_n), .layout_new(layout_new), .cfg_we(cfg_we),
    .cfg_mask(cfg_mask), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_row(out_row), .row_min(row_min), .row_max(row_max)
  );

  // {layout, addr, expected hit, expected row}
  localparam logic [44:0] VEC [0:14] = '{
    {1'b0, 40'h00_0200_0000, 1'b1, 3'd0},  // R4 row0 exact
    {1'b0, 40'h00_0400_1234, 1'b1, 3'd1},  // R3 low gap bits ignored
    {1'b0, 40'h00_0600_0000, 1'b1, 3'd2},  // R5 rows 2 and 6 both match
    {1'b0, 40'h00_0C00_0000, 1'b0, 3'd0},  // R1 row5 disabled
    {1'b0, 40'h00_1000_0000, 1'b1, 3'd7},  // R4 row7 exact
    {1'b0, 40'h00_1200_0000, 1'b1, 3'd7},  // R3 mask bit set by reg 7
    {1'b0, 40'h00_0400_2000, 1'b0, 3'd0},  // R4 stored field bit differs
    {1'b0, 40'h00_0410_0000, 1'b1, 3'd1},  // R3 gap bit 20
    {1'b0, 40'h00_0000_0000, 1'b0, 3'd0},  // R6 no row
    {1'b0, 40'h10_0800_0000, 1'b1, 3'd3},  // R3 bits above fields ignored
    {1'b0, 40'h00_2000_0000, 1'b0, 3'd0},  // R2 layout0 shift 4 miss
    {1'b1, 40'h01_0000_0000, 1'b1, 3'd7},  // R2 layout1 row7
    {1'b1, 40'h01_2000_0000, 1'b0, 3'd0},  // R7 mask reg 7 unused
    {1'b1, 40'h00_2040_0000, 1'b1, 3'd0},  // R2 layout1 gap bit 22
    {1'b1, 40'h00_6000_0000, 1'b1, 3'd2}   // R5 layout1 priority
  };

  function automatic logic [31:0] fld(bit lay);
    return lay ? 32'h1FF8_3FE0 : 32'hFFE0_FE00;
  endfunction
  function automatic int sh(bit lay);
    return lay ? 8 : 4;
  endfunction
  function automatic logic [39:0] xbase(bit lay, logic [31:0] b);
    return {8'h0, b & fld(lay)} << sh(lay);
  endfunction
  function automatic logic [39:0] xmask(bit lay, logic [31:0] m);
    return ({8'h0, m & fld(lay)} << sh(lay)) | ~({8'h0, fld(lay)} << sh(lay));
  endfunction
  function automatic logic [39:0] xgap(bit lay);
    return lay ? 40'h00_07C0_1FFF : 40'h00_01F0_1FFF;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(bit m, int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mask = m; cfg_idx = 3'(idx); cfg_data = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(bit lay, logic [39:0] a, bit eh, logic [2:0] er, string req);
    @(negedge clk);
    layout_new = lay; in_addr = a; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, "out_valid", 64'(out_valid), 64'd1);
    chk(out_hit == eh, req, "out_hit", 64'(out_hit), 64'(eh));
    chk(out_row == er, req, "out_row", 64'(out_row), 64'(er));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(out_hit == 1'b0 && out_row == 3'd0, "R10", "hit/row in reset",
        64'({out_hit, out_row}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(row_min[39:0] == 40'd0, "R10", "row0 min after reset", 64'(row_min[39:0]), 64'd0);
    chk(in_ready == 1'b1, "R9", "in_ready idle", 64'(in_ready), 64'd1);
    // R10/R1 all rows disabled after reset
    look(1'b0, 40'h00_0200_0000, 1'b0, 3'd0, "R10");

    // R11 load configuration
    for (int r = 0; r < 8; r++) begin
      logic [31:0] b;
      b = (32'(r + 1) << 21) | 32'd1;
      if (r == 5) b = 32'(r + 1) << 21;
      if (r == 6) b = (32'd3 << 21) | 32'd1;
      wr(1'b0, r, b);
    end
    wr(1'b1, 7, 32'h0020_0000);
    look(1'b0, 40'h00_0200_0000, 1'b1, 3'd0, "R11");

    for (int i = 0; i < 15; i++) begin
      look(VEC[i][44], VEC[i][43:4], VEC[i][3], VEC[i][2:0], $sformatf("R4 vec%0d", i));
    end

    // R2 exact expanded base for row3 in layout0
    @(negedge clk); layout_new = 1'b0;
    #1 chk(row_min[3*40 +: 40] == 40'h00_0800_0000, "R2", "row3 min",
           64'(row_min[3*40 +: 40]), 64'h0800_0000);
    // R8 row7 range in layout0
    chk(row_max[7*40 +: 40] == (xbase(0, (32'd8 << 21) | 1) | xmask(0, 32'h0020_0000) | xgap(0)),
        "R8", "row7 max", 64'(row_max[7*40 +: 40]),
        64'(xbase(0, (32'd8 << 21) | 1) | xmask(0, 32'h0020_0000) | xgap(0)));

    // R7 shared mask in layout1: mask reg0 affects rows 0 and 1
    wr(1'b1, 0, 32'h0020_0000);
    look(1'b1, 40'h00_0000_0000, 1'b1, 3'd0, "R7");
    look(1'b1, 40'h00_6000_0000, 1'b1, 3'd1, "R7");
    @(negedge clk); layout_new = 1'b1;
    #1 chk(row_min[39:0] == (xbase(1, (32'd1 << 21) | 1) & ~xmask(1, 32'h0020_0000)),
           "R8", "row0 min layout1", 64'(row_min[39:0]),
           64'(xbase(1, (32'd1 << 21) | 1) & ~xmask(1, 32'h0020_0000)));
    chk(row_max[39:0] == (xbase(1, (32'd1 << 21) | 1) | xmask(1, 32'h0020_0000) | xgap(1)),
        "R8", "row0 max layout1", 64'(row_max[39:0]),
        64'(xbase(1, (32'd1 << 21) | 1) | xmask(1, 32'h0020_0000) | xgap(1)));

    // R9 back-pressure
    @(negedge clk);
    layout_new = 1'b0; out_ready = 1'b0; in_valid = 1'b1; in_addr = 40'h00_0200_0000;
    @(posedge clk);
    @(negedge clk);
    in_addr = 40'h00_1000_0000;
    chk(in_ready == 1'b0, "R9", "in_ready stalled", 64'(in_ready), 64'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid && out_hit && out_row == 3'd0, "R9", "held result",
        64'({out_valid, out_hit, out_row}), 64'({1'b1, 1'b1, 3'd0}));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_hit && out_row == 3'd7, "R9", "second result",
        64'({out_valid, out_hit, out_row}), 64'({1'b1, 1'b1, 3'd7}));
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule